// File: doc/BRIEF.md
# Integer Execute Unit with Signed Set-Less-Than

This block is the integer execute stage of a 32-bit load/store pipeline, together with the 32-entry register bank it reads and writes. A valid operation supplies an operation code, a destination index, two source indices and a 16-bit immediate. The datapath is combinational and produces a 32-bit result and a write-enable within the same cycle. On the next rising clock edge the result is committed to the destination register.

The operations are register add and subtract, add-immediate, load-upper-immediate, shift-left-by-immediate and signed set-less-than. Register 0 is wired to zero, so subtracting a register from itself is the usual way to clear one. The two source read values are also brought out as ports, which lets the surrounding pipeline, or a bench, observe register contents without any extra access path.

Top module: `int_exec_unit`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers, so every register reads 0 after reset.
- R2: Register 0 reads as 0 on both source ports, and a write addressed to it is discarded.
- R3: Operation code 1 (add) gives result = reg[rs1] + reg[rs2], modulo 2^32.
- R4: Operation code 2 (subtract) gives result = reg[rs1] - reg[rs2], modulo 2^32. With rs1 equal to rs2 the result is 0.
- R5: Operation code 3 (add-immediate) gives result = reg[rs1] + imm, where imm is sign-extended from bit 15 to 32 bits.
- R6: Operation code 4 (load-upper) gives result = {imm, 16'h0000}, whatever the source registers hold.
- R7: Operation code 5 (shift-left) gives result = reg[rs1] << imm[4:0], filling with zeros. Immediate bits 15..5 are ignored.
- R8: Operation code 6 (set-less-than) gives result 1 when reg[rs1] < reg[rs2] as signed two's-complement values, and 0 otherwise. Bits 31..1 are always 0.
- R9: When valid is high and the operation code is 1 to 6, wr_en is 1 and the result is stored into rd at the next rising edge. A source read in that same cycle returns the register's old value.
- R10: Operation codes 0 and 7, or valid low, give wr_en = 0 and change no register. Codes 0 and 7 also give result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid | input | 1 | An operation is issued this cycle |
| op | input | 3 | Operation code (0 no-op, 1 add, 2 sub, 3 add-imm, 4 load-upper, 5 shift-left, 6 set-less-than, 7 no-op) |
| rd | input | 5 | Destination register index |
| rs1 | input | 5 | First source register index |
| rs2 | input | 5 | Second source register index |
| imm | input | 16 | Immediate operand |
| result | output | 32 | Combinational execute result |
| wr_en | output | 1 | Result will be written to rd at the next edge |
| src_a | output | 32 | Current value of register rs1 |
| src_b | output | 32 | Current value of register rs2 |

## Verification
A corrupted register shows up on src_a or src_b in the first cycle in which any operation names that register as a source. It also carries into every later result computed from it. An error in the datapath selection or the adder shows on result in the same cycle it is issued, before any edge. A lost or misdirected write shows one cycle later, when the destination is read back. The bench keeps a shadow register bank and reads every affected register soon after each write, so a fault is reported within a few operations of its cause.

// File: rtl/exu_pkg.sv
`timescale 1ns/1ps
package exu_pkg;

    localparam int XLEN    = 32;
    localparam int IMMW    = 16;
    localparam int NREG    = 32;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int SHAMT_W = $clog2(XLEN);

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [IMMW-1:0]   imm_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_ADDI = 3'd3,
        OP_LHI  = 3'd4,
        OP_SLLI = 3'd5,
        OP_SLT  = 3'd6,
        OP_RSV  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        SEL_ZERO,
        SEL_SUM,
        SEL_UPPER,
        SEL_SHIFT,
        SEL_LESS
    } sel_e;

    typedef struct packed {
        logic writes;
        logic use_imm;
        logic negate;
        sel_e sel;
    } ctrl_t;

    function automatic word_t sext_imm(input imm_t v);
        return {{(XLEN-IMMW){v[IMMW-1]}}, v};
    endfunction

    function automatic word_t upper_imm(input imm_t v);
        return {v, {(XLEN-IMMW){1'b0}}};
    endfunction

endpackage

// File: rtl/exu_regfile.sv
`timescale 1ns/1ps
module exu_regfile #(
    parameter int W = 32,
    parameter int N = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [W-1:0] bank [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign bank[g] = '0;
        end else begin : g_store
            logic [W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (we && (waddr == AW'(g))) begin
                    q <= wdata;
                end
            end
            assign bank[g] = q;
        end
    end

    assign rdata_a = bank[raddr_a];
    assign rdata_b = bank[raddr_b];

endmodule

// File: rtl/exu_decode.sv
`timescale 1ns/1ps
module exu_decode
    import exu_pkg::*;
(
    input  logic  [2:0] op_code,
    output ctrl_t       ctrl
);

    op_e op;
    assign op = op_e'(op_code);

    always_comb begin
        ctrl = '{writes: 1'b0, use_imm: 1'b0, negate: 1'b0, sel: SEL_ZERO};
        unique case (op)
            OP_ADD:  ctrl = '{writes: 1'b1, use_imm: 1'b0, negate: 1'b0, sel: SEL_SUM};
            OP_SUB:  ctrl = '{writes: 1'b1, use_imm: 1'b0, negate: 1'b1, sel: SEL_SUM};
            OP_ADDI: ctrl = '{writes: 1'b1, use_imm: 1'b1, negate: 1'b0, sel: SEL_SUM};
            OP_LHI:  ctrl = '{writes: 1'b1, use_imm: 1'b1, negate: 1'b0, sel: SEL_UPPER};
            OP_SLLI: ctrl = '{writes: 1'b1, use_imm: 1'b1, negate: 1'b0, sel: SEL_SHIFT};
            OP_SLT:  ctrl = '{writes: 1'b1, use_imm: 1'b0, negate: 1'b1, sel: SEL_LESS};
            OP_NOP, OP_RSV: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/exu_shifter.sv
`timescale 1ns/1ps
module exu_shifter #(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amount,
    output logic [W-1:0]  dout
);

    logic [W-1:0] stage [SW+1];
    assign stage[0] = din;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amount[k] ? {stage[k][W-1-STEP:0], {STEP{1'b0}}}
                                      : stage[k];
    end

    assign dout = stage[SW];

endmodule

// File: rtl/exu_alu.sv
`timescale 1ns/1ps
module exu_alu
    import exu_pkg::*;
(
    input  ctrl_t ctrl,
    input  word_t opa,
    input  word_t opb,
    input  imm_t  imm,
    output word_t res
);

    word_t second;
    word_t addend;
    word_t sum;
    word_t shifted;
    logic  less;

    assign second = ctrl.use_imm ? sext_imm(imm) : opb;
    assign addend = ctrl.negate ? ~second : second;
    assign sum    = opa + addend + XLEN'(ctrl.negate);

    // Signed compare from the shared subtractor: differing signs decide directly.
    assign less = (opa[XLEN-1] ^ second[XLEN-1]) ? opa[XLEN-1] : sum[XLEN-1];

    exu_shifter #(.W(XLEN)) u_shl (
        .din    (opa),
        .amount (imm[SHAMT_W-1:0]),
        .dout   (shifted)
    );

    always_comb begin
        unique case (ctrl.sel)
            SEL_SUM:   res = sum;
            SEL_UPPER: res = upper_imm(imm);
            SEL_SHIFT: res = shifted;
            SEL_LESS:  res = {{(XLEN-1){1'b0}}, less};
            default:   res = '0;
        endcase
    end

endmodule

// File: rtl/int_exec_unit.sv
`timescale 1ns/1ps
module int_exec_unit
    import exu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        valid,
    input  logic [2:0]  op,
    input  logic [4:0]  rd,
    input  logic [4:0]  rs1,
    input  logic [4:0]  rs2,
    input  logic [15:0] imm,
    output logic [31:0] result,
    output logic        wr_en,
    output logic [31:0] src_a,
    output logic [31:0] src_b
);

    ctrl_t ctrl;
    word_t alu_out;
    word_t rd_a;
    word_t rd_b;

    exu_decode u_dec (
        .op_code (op),
        .ctrl    (ctrl)
    );

    exu_regfile #(.W(XLEN), .N(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .waddr   (rd),
        .wdata   (alu_out),
        .raddr_a (rs1),
        .raddr_b (rs2),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    exu_alu u_alu (
        .ctrl (ctrl),
        .opa  (rd_a),
        .opb  (rd_b),
        .imm  (imm),
        .res  (alu_out)
    );

    assign wr_en  = valid & ctrl.writes;
    assign result = alu_out;
    assign src_a  = rd_a;
    assign src_b  = rd_b;

endmodule

// File: rtl/int_exec_unit_chk.sv
`timescale 1ns/1ps
module int_exec_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        valid,
    input logic [2:0]  op,
    input logic [4:0]  rd,
    input logic [4:0]  rs1,
    input logic [4:0]  rs2,
    input logic [15:0] imm,
    input logic [31:0] result,
    input logic        wr_en,
    input logic [31:0] src_a,
    input logic [31:0] src_b
);

    // R2
    zero_reg_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rs1 == 5'd0) |-> (src_a == 32'd0));

    // R6
    upper_low_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd4) |-> (result[15:0] == 16'd0 && result[31:16] == imm));

    // R8
    less_is_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd6) |-> (result[31:1] == 31'd0));

    // R9
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && $past(rd) != 5'd0 && rs1 == $past(rd))
        |-> (src_a == $past(result)));

    // R10
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid || op == 3'd0 || op == 3'd7) |-> !wr_en);

    // R7
    shift_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (op == 3'd5 && imm[4:0] != 5'd0) |-> (result[0] == 1'b0));

endmodule

bind int_exec_unit int_exec_unit_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .valid  (valid),
    .op     (op),
    .rd     (rd),
    .rs1    (rs1),
    .rs2    (rs2),
    .imm    (imm),
    .result (result),
    .wr_en  (wr_en),
    .src_a  (src_a),
    .src_b  (src_b)
);

// File: tb/int_exec_unit_test.sv
`timescale 1ns/1ps
module int_exec_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [4:0]  rd = 5'd0;
    logic [4:0]  rs1 = 5'd0;
    logic [4:0]  rs2 = 5'd0;
    logic [15:0] imm = 16'd0;
    logic [31:0] result;
    logic        wr_en;
    logic [31:0] src_a;
    logic [31:0] src_b;

    int total = 0;
    int bad = 0;
    logic [31:0] shadow [32];
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    int_exec_unit uut (
        .clk(clk), .rst(rst), .valid(valid), .op(op), .rd(rd), .rs1(rs1),
        .rs2(rs2), .imm(imm), .result(result), .wr_en(wr_en),
        .src_a(src_a), .src_b(src_b)
    );

    function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] a,
                                          input logic [31:0] b, input logic [15:0] i);
        case (o)
            3'd1: return a + b;
            3'd2: return a - b;
            3'd3: return a + {{16{i[15]}}, i};
            3'd4: return {i, 16'h0000};
            3'd5: return a << i[4:0];
            3'd6: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input string req, input logic v, input logic [2:0] o,
                         input logic [4:0] d, input logic [4:0] a, input logic [4:0] b,
                         input logic [15:0] i);
        logic [31:0] exp;
        logic        wexp;
        @(negedge clk);
        valid = v; op = o; rd = d; rs1 = a; rs2 = b; imm = i;
        #1;
        exp  = model(o, shadow[a], shadow[b], i);
        wexp = v && (o != 3'd0) && (o != 3'd7);
        check(req, "result", result, exp);
        check(req, "wr_en", {31'd0, wr_en}, {31'd0, wexp});
        check(req, "src_a", src_a, shadow[a]);
        check(req, "src_b", src_b, shadow[b]);
        @(posedge clk);
        if (wexp && d != 5'd0) shadow[d] = exp;
    endtask

    task automatic load(input logic [4:0] d, input logic [31:0] val);
        logic [31:0] hi;
        hi = val - {{16{val[15]}}, val[15:0]};
        issue("R6", 1'b1, 3'd4, d, 5'd0, 5'd0, hi[31:16]);
        issue("R5", 1'b1, 3'd3, d, d, 5'd0, val[15:0]);
    endtask

    task automatic t_reset;
        for (int r = 0; r < 32; r++) issue("R1", 1'b0, 3'd0, 5'd0, 5'(r), 5'(r), 16'd0);
    endtask

    task automatic t_zero_reg;
        load(5'd0, 32'hDEAD_BEEF);
        issue("R2", 1'b1, 3'd1, 5'd1, 5'd0, 5'd0, 16'd0);
        check("R2", "r0 after write", src_a, 32'd0);
    endtask

    task automatic t_add;
        load(5'd1, 32'h7FFF_FFFF);
        load(5'd2, 32'h0000_0001);
        load(5'd3, 32'hFFFF_FFFF);
        issue("R3", 1'b1, 3'd1, 5'd4, 5'd1, 5'd2, 16'd0);
        issue("R3", 1'b1, 3'd1, 5'd5, 5'd3, 5'd2, 16'd0);
        issue("R3", 1'b1, 3'd1, 5'd6, 5'd3, 5'd3, 16'd0);
    endtask

    task automatic t_sub;
        load(5'd7, 32'h8000_0000);
        issue("R4", 1'b1, 3'd2, 5'd8, 5'd7, 5'd2, 16'd0);
        issue("R4", 1'b1, 3'd2, 5'd9, 5'd2, 5'd3, 16'd0);
        issue("R4", 1'b1, 3'd2, 5'd7, 5'd7, 5'd7, 16'd0);
        issue("R4", 1'b0, 3'd0, 5'd0, 5'd7, 5'd0, 16'd0);
    endtask

    task automatic t_addi;
        issue("R5", 1'b1, 3'd3, 5'd10, 5'd2, 5'd0, 16'hFFFF);
        issue("R5", 1'b1, 3'd3, 5'd11, 5'd1, 5'd0, 16'h7FFF);
        issue("R5", 1'b1, 3'd3, 5'd12, 5'd0, 5'd0, 16'h8000);
    endtask

    task automatic t_lhi;
        issue("R6", 1'b1, 3'd4, 5'd13, 5'd3, 5'd1, 16'h002A);
        issue("R6", 1'b1, 3'd4, 5'd14, 5'd1, 5'd3, 16'hFFFF);
    endtask

    task automatic t_slli;
        load(5'd15, 32'hA5A5_0F0F);
        issue("R7", 1'b1, 3'd5, 5'd16, 5'd15, 5'd0, 16'd0);
        issue("R7", 1'b1, 3'd5, 5'd16, 5'd15, 5'd0, 16'd5);
        issue("R7", 1'b1, 3'd5, 5'd16, 5'd15, 5'd0, 16'd31);
        issue("R7", 1'b1, 3'd5, 5'd16, 5'd15, 5'd0, 16'hFFE4);
    endtask

    task automatic t_slt;
        issue("R8", 1'b1, 3'd6, 5'd17, 5'd7, 5'd1, 16'd0);
        issue("R8", 1'b1, 3'd6, 5'd17, 5'd3, 5'd0, 16'd0);
        issue("R8", 1'b1, 3'd6, 5'd17, 5'd0, 5'd3, 16'd0);
        issue("R8", 1'b1, 3'd6, 5'd17, 5'd1, 5'd1, 16'd0);
        load(5'd18, 32'h8000_0000);
        issue("R8", 1'b1, 3'd6, 5'd17, 5'd18, 5'd1, 16'd0);
        issue("R8", 1'b1, 3'd6, 5'd17, 5'd1, 5'd18, 16'd0);
    endtask

    task automatic t_same_cycle;
        load(5'd20, 32'd100);
        issue("R9", 1'b1, 3'd3, 5'd20, 5'd20, 5'd20, 16'd7);
        issue("R9", 1'b0, 3'd0, 5'd0, 5'd20, 5'd0, 16'd0);
        check("R9", "written value", src_a, 32'd107);
    endtask

    task automatic t_idle;
        load(5'd21, 32'h1234_5678);
        issue("R10", 1'b0, 3'd1, 5'd21, 5'd1, 5'd2, 16'd0);
        issue("R10", 1'b1, 3'd0, 5'd21, 5'd1, 5'd2, 16'd0);
        issue("R10", 1'b1, 3'd7, 5'd21, 5'd1, 5'd2, 16'd0);
        issue("R10", 1'b0, 3'd0, 5'd0, 5'd21, 5'd0, 16'd0);
        check("R10", "r21 kept", src_a, 32'h1234_5678);
    endtask

    task automatic t_random;
        logic [31:0] corner [4];
        corner[0] = 32'd0; corner[1] = 32'hFFFF_FFFF;
        corner[2] = 32'h7FFF_FFFF; corner[3] = 32'h8000_0000;
        for (int k = 0; k < 4; k++) load(5'(22 + k), corner[k]);
        for (int n = 0; n < 300; n++) begin
            logic [2:0] o;
            o = 3'($urandom_range(1, 6));
            issue(o == 3'd1 ? "R3" : o == 3'd2 ? "R4" : o == 3'd3 ? "R5" :
                  o == 3'd4 ? "R6" : o == 3'd5 ? "R7" : "R8",
                  1'b1, o, 5'($urandom_range(1, 31)), 5'($urandom_range(0, 31)),
                  5'($urandom_range(0, 31)), 16'($urandom));
        end
    endtask

    initial begin
        for (int r = 0; r < 32; r++) shadow[r] = 32'd0;
        void'($urandom(7));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_zero_reg();
        t_add();
        t_sub();
        t_addi();
        t_lhi();
        t_slli();
        t_slt();
        t_same_cycle();
        t_idle();
        t_random();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule